// File: doc/BRIEF.md
# Stereo Capture Block Buffer with Primed Four-Slot Playback

The block sits between a stream of 16-bit audio-rate sample words and a sink that consumes I/Q sample pairs. Incoming words alternate between the left (I) and right (Q) channel. They are written into a capture store made of two equal banks, used alternately. When a bank fills, the block raises a one-cycle completion event that names the bank. A copy engine then moves that bank into one slot of a four-slot playback ring. On the way it splits the words into I and Q and passes them through a fixed-latency processing hook, which is a plain pipeline here.

Playback is held back after every start and every restart until the ring holds four complete blocks. After that the ring is read in slot order, one I/Q pair per output handshake. Suppose a newly captured block is due while the ring is full of unplayed data, so that its destination slot still holds the play cursor. The block does not overwrite that slot. It discards everything unplayed, returns the play and write cursors to slot 0, pulses a restart flag, and primes again with the new block first. Dropping the run input stops capture and playback and clears all cursors. Raising it again starts a fresh priming pass.

The input stream follows valid/ready rules. `in_ready` is high whenever `run` is high, so a word is taken on every rising edge where both `in_valid` and `run` are high. The output stream holds `out_valid` and its data steady while `out_ready` is low. A restart or a drop of `run` withdraws an offered pair without a handshake. Back-pressure stalls only the play cursor. Capture keeps running, so a sink that stalls for long enough causes a restart.

Top module: `pp_capture_ring`

## Requirements
- R1: While `run` is low, `in_ready`, `out_valid`, `playing`, `half_ready` and `restart` are all low one cycle later, and capture restarts at bank 0, word 0 when `run` returns high.
- R2: `half_ready` pulses for exactly one cycle, the cycle after the last word of a bank (block size BLOCK_WORDS) is accepted. `half_sel` is 0 for the first bank after a start and alternates 1, 0, 1 on each later event.
- R3: Within each block, the words at even positions (0, 2, 4, ...) appear on `out_i` and the words at odd positions on `out_q`. Each output beat carries one pair, taken from adjacent words.
- R4: After a start or a restart, `out_valid` and `playing` stay low until SLOTS (4) blocks have been copied into the ring. After that `playing` is high and pairs are offered.
- R5: When no restart occurs, the sequence of output pairs equals the sequence of input pairs delayed by four blocks. No pair is offered before 4·BLOCK_WORDS words have been accepted.
- R6: A bank completion that arrives while `playing` is high and all four slots hold unplayed data makes `restart` pulse for one cycle, two cycles after that bank's last word is accepted. All unplayed pairs are dropped and `playing` falls. The new block becomes the first block of the next priming pass.
- R7: While `out_valid` is high and `out_ready` is low, the next cycle keeps `out_valid` high with unchanged `out_i`/`out_q`, unless `restart` is high or `run` falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | High to capture and play, low to stop and clear |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted when high with in_valid |
| in_data | input | 16 | Interleaved sample word (even = I, odd = Q) |
| out_valid | output | 1 | Output pair valid |
| out_ready | input | 1 | Sink accepts the pair |
| out_i | output | 16 | I sample of the pair |
| out_q | output | 16 | Q sample of the pair |
| half_ready | output | 1 | One-cycle capture bank completion event |
| half_sel | output | 1 | Bank that completed (0 or 1) |
| playing | output | 1 | Ring primed and playback active |
| restart | output | 1 | One-cycle pulse on each collision flush |

## Verification
`half_ready` is due one cycle after the accepting edge of a bank's last word and `restart` two cycles after it. The bench keeps a short pipeline of expected flags and compares both outputs against it at every falling edge. Output pairs arrive a variable number of cycles after their block completes, depending on copy time and back-pressure. For that reason the data is compared at each output handshake against the front of a queue of captured pairs. That queue is filled, primed and flushed by the requirement rules at block granularity. Stall windows are checked cycle by cycle for stable data, and the stimulus keeps the sink either fully ready or fully stalled around a bank completion, so that the collision decision does not race a slot finishing playback.

// File: rtl/pp_ring_pkg.sv
package pp_ring_pkg;

  typedef struct packed {
    logic [15:0] q;
    logic [15:0] i;
  } iq_pair_t;

endpackage

// File: rtl/pp_cap_banks.sv
module pp_cap_banks
  import pp_ring_pkg::*;
#(
  parameter int BLOCK_WORDS = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic in_valid,
  input  logic [15:0] in_data,
  output logic in_ready,
  output logic half_ready,
  output logic half_sel,
  input  logic rd_half,
  input  logic [$clog2(BLOCK_WORDS/2)-1:0] rd_pair,
  output iq_pair_t rd_word
);
  localparam int DEPTH = 2 * BLOCK_WORDS;
  localparam int AW    = $clog2(DEPTH);

  logic [AW-1:0] wr_ptr;
  logic          take;
  logic [15:0]   bank_i [2];
  logic [15:0]   bank_q [2];

  assign in_ready = run;
  assign take     = in_valid && run;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      wr_ptr     <= '0;
      half_ready <= 1'b0;
      half_sel   <= 1'b0;
    end else begin
      half_ready <= take && (wr_ptr[AW-2:0] == '1);
      if (take && (wr_ptr[AW-2:0] == '1)) half_sel <= wr_ptr[AW-1];
      if (take) wr_ptr <= wr_ptr + 1'b1;
    end
  end

  for (genvar h = 0; h < 2; h++) begin : g_bank
    logic [15:0] mem [BLOCK_WORDS];
    always_ff @(posedge clk) begin
      if (take && (wr_ptr[AW-1] == 1'(h))) mem[wr_ptr[AW-2:0]] <= in_data;
    end
    assign bank_i[h] = mem[{rd_pair, 1'b0}];
    assign bank_q[h] = mem[{rd_pair, 1'b1}];
  end

  always_comb begin
    rd_word.i = rd_half ? bank_i[1] : bank_i[0];
    rd_word.q = rd_half ? bank_q[1] : bank_q[0];
  end
endmodule

// File: rtl/pp_blk_mover.sv
module pp_blk_mover
  import pp_ring_pkg::*;
#(
  parameter int BLOCK_WORDS = 32,
  parameter int SLOTS       = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic half_ready,
  input  logic half_sel,
  input  logic collide,
  output logic src_half,
  output logic [$clog2(BLOCK_WORDS/2)-1:0] src_pair,
  output logic mv_valid,
  output logic mv_last,
  output logic [$clog2(SLOTS)+$clog2(BLOCK_WORDS/2)-1:0] mv_addr,
  output logic flush
);
  localparam int PAIRS = BLOCK_WORDS / 2;
  localparam int PW    = $clog2(PAIRS);
  localparam int SW    = $clog2(SLOTS);

  logic          busy;
  logic [PW-1:0] pair_cnt;
  logic          half_r;
  logic [SW-1:0] slot;
  logic          at_end;

  assign at_end   = (pair_cnt == PW'(PAIRS - 1));
  assign src_half = half_r;
  assign src_pair = pair_cnt;
  assign mv_valid = busy;
  assign mv_last  = busy && at_end;
  assign mv_addr  = {slot, pair_cnt};

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      busy     <= 1'b0;
      pair_cnt <= '0;
      half_r   <= 1'b0;
      slot     <= '0;
      flush    <= 1'b0;
    end else begin
      flush <= 1'b0;
      if (busy) begin
        pair_cnt <= pair_cnt + 1'b1;
        if (at_end) begin
          busy <= 1'b0;
          slot <= slot + 1'b1;
        end
      end
      if (half_ready) begin
        busy     <= 1'b1;
        pair_cnt <= '0;
        half_r   <= half_sel;
        flush    <= collide;
        if (collide) slot <= '0;
      end
    end
  end
endmodule

// File: rtl/pp_iq_hook.sv
module pp_iq_hook
  import pp_ring_pkg::*;
#(
  parameter int AW     = 6,
  parameter int STAGES = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic in_v,
  input  logic in_last,
  input  logic [AW-1:0] in_addr,
  input  iq_pair_t in_data,
  output logic out_v,
  output logic out_last,
  output logic [AW-1:0] out_addr,
  output iq_pair_t out_data
);
  localparam int W = 2 + AW + 32;

  logic [W-1:0] head;
  logic [W-1:0] tail;

  assign head = {in_v, in_last, in_addr, in_data};

  if (STAGES == 0) begin : g_wire
    assign tail = head;
  end else begin : g_pipe
    logic [W-1:0] stage [STAGES];
    for (genvar s = 0; s < STAGES; s++) begin : g_st
      always_ff @(posedge clk) begin
        if (!rst_n || !run) stage[s] <= '0;
        else if (s == 0)    stage[s] <= head;
        else                stage[s] <= stage[(s == 0) ? 0 : s - 1];
      end
    end
    assign tail = stage[STAGES-1];
  end

  assign {out_v, out_last, out_addr, out_data} = tail;
endmodule

// File: rtl/pp_play_ring.sv
module pp_play_ring
  import pp_ring_pkg::*;
#(
  parameter int BLOCK_WORDS = 32,
  parameter int SLOTS       = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic wr_en,
  input  logic wr_last,
  input  logic [$clog2(SLOTS)+$clog2(BLOCK_WORDS/2)-1:0] wr_addr,
  input  iq_pair_t wr_data,
  input  logic flush,
  input  logic out_ready,
  output logic out_valid,
  output iq_pair_t out_data,
  output logic playing,
  output logic collide
);
  localparam int PAIRS = BLOCK_WORDS / 2;
  localparam int PW    = $clog2(PAIRS);
  localparam int RAW   = $clog2(SLOTS) + PW;
  localparam int DEPTH = SLOTS * PAIRS;
  localparam int OW    = $clog2(SLOTS + 1);

  iq_pair_t       mem [DEPTH];
  logic [RAW-1:0] rd_ptr;
  logic [OW-1:0]  occ;
  logic           fire, consumed, added;

  assign out_valid = run && playing && (occ != '0);
  assign out_data  = mem[rd_ptr];
  assign fire      = out_valid && out_ready;
  assign consumed  = fire && (rd_ptr[PW-1:0] == '1);
  assign added     = wr_en && wr_last;
  assign collide   = playing && (occ == OW'(SLOTS));

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !run || flush) begin
      rd_ptr  <= '0;
      occ     <= '0;
      playing <= 1'b0;
    end else begin
      occ <= occ + OW'(added) - OW'(consumed);
      if (fire) rd_ptr <= rd_ptr + 1'b1;
      if (!playing && added && (occ == OW'(SLOTS - 1))) playing <= 1'b1;
    end
  end
endmodule

// File: rtl/pp_capture_ring.sv
module pp_capture_ring
  import pp_ring_pkg::*;
#(
  parameter int BLOCK_WORDS = 32,
  parameter int SLOTS       = 4,
  parameter int HOOK_STAGES = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        run,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [15:0] in_data,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [15:0] out_i,
  output logic [15:0] out_q,
  output logic        half_ready,
  output logic        half_sel,
  output logic        playing,
  output logic        restart
);
  localparam int PW  = $clog2(BLOCK_WORDS / 2);
  localparam int RAW = $clog2(SLOTS) + PW;

  logic           src_half;
  logic [PW-1:0]  src_pair;
  iq_pair_t       src_word;
  logic           mv_valid, mv_last;
  logic [RAW-1:0] mv_addr;
  logic           hk_valid, hk_last;
  logic [RAW-1:0] hk_addr;
  iq_pair_t       hk_data;
  logic           collide;
  iq_pair_t       play_word;

  pp_cap_banks #(.BLOCK_WORDS(BLOCK_WORDS)) u_cap (
    .clk(clk), .rst_n(rst_n), .run(run),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .half_ready(half_ready), .half_sel(half_sel),
    .rd_half(src_half), .rd_pair(src_pair), .rd_word(src_word)
  );

  pp_blk_mover #(.BLOCK_WORDS(BLOCK_WORDS), .SLOTS(SLOTS)) u_mover (
    .clk(clk), .rst_n(rst_n), .run(run),
    .half_ready(half_ready), .half_sel(half_sel), .collide(collide),
    .src_half(src_half), .src_pair(src_pair),
    .mv_valid(mv_valid), .mv_last(mv_last), .mv_addr(mv_addr),
    .flush(restart)
  );

  pp_iq_hook #(.AW(RAW), .STAGES(HOOK_STAGES)) u_hook (
    .clk(clk), .rst_n(rst_n), .run(run),
    .in_v(mv_valid), .in_last(mv_last), .in_addr(mv_addr), .in_data(src_word),
    .out_v(hk_valid), .out_last(hk_last), .out_addr(hk_addr), .out_data(hk_data)
  );

  pp_play_ring #(.BLOCK_WORDS(BLOCK_WORDS), .SLOTS(SLOTS)) u_ring (
    .clk(clk), .rst_n(rst_n), .run(run),
    .wr_en(hk_valid), .wr_last(hk_last), .wr_addr(hk_addr), .wr_data(hk_data),
    .flush(restart), .out_ready(out_ready),
    .out_valid(out_valid), .out_data(play_word),
    .playing(playing), .collide(collide)
  );

  assign out_i = play_word.i;
  assign out_q = play_word.q;
endmodule

// File: rtl/pp_capture_ring_chk.sv
module pp_capture_ring_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        run,
  input logic        out_valid,
  input logic        out_ready,
  input logic [15:0] out_i,
  input logic [15:0] out_q,
  input logic        half_ready,
  input logic        half_sel,
  input logic        playing,
  input logic        restart
);
  logic seen, last_sel;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      seen     <= 1'b0;
      last_sel <= 1'b0;
    end else if (half_ready) begin
      seen     <= 1'b1;
      last_sel <= half_sel;
    end
  end

  // R1
  stop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!playing && !out_valid && !half_ready && !restart));

  // R2
  half_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    half_ready |=> !half_ready);

  // R2
  half_alternate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (half_ready && run) |-> (seen ? (half_sel != last_sel) : (half_sel == 1'b0)));

  // R4
  prime_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> playing);

  // R6
  restart_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !restart);

  // R6
  restart_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |-> $past(half_ready));

  // R6
  restart_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (!playing && !out_valid));

  // R7
  hold_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !restart) |=>
      ((out_valid && $stable(out_i) && $stable(out_q)) || !run));
endmodule

bind pp_capture_ring pp_capture_ring_chk u_chk (
  .clk(clk), .rst_n(rst_n), .run(run),
  .out_valid(out_valid), .out_ready(out_ready),
  .out_i(out_i), .out_q(out_q),
  .half_ready(half_ready), .half_sel(half_sel),
  .playing(playing), .restart(restart)
);

// File: tb/tb_pp_capture_ring.sv
`timescale 1ns/1ps
module tb_pp_capture_ring;
  localparam int BLK   = 32;
  localparam int SLOTS = 4;
  localparam int PAIRS = BLK / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0, run = 1'b0, in_valid = 1'b0, out_ready = 1'b0;
  logic [15:0] in_data = '0;
  logic in_ready, out_valid, half_ready, half_sel, playing, restart;
  logic [15:0] out_i, out_q;

  always #10 clk = ~clk;

  pp_capture_ring #(.BLOCK_WORDS(BLK), .SLOTS(SLOTS), .HOOK_STAGES(1)) dut (
    .clk(clk), .rst_n(rst_n), .run(run),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_i(out_i), .out_q(out_q),
    .half_ready(half_ready), .half_sel(half_sel), .playing(playing), .restart(restart)
  );

  int checks = 0, fails = 0;
  int seed = 1, beats = 0, restarts_seen = 0, restarts_exp = 0;

  // reference model state
  logic [31:0] q_m [$];
  logic [31:0] blk_m [$];
  logic [15:0] pend_i;
  int  wcnt = 0;
  bit  playing_m = 0;
  bit  ev_p = 0, evsel_p = 0, rs_p1 = 0, rs_p2 = 0;
  bit  hold_v = 0;
  logic [31:0] hold_d;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk(in_ready == run, "R1", "in_ready follows run", in_ready, run);
      chk(half_ready == ev_p, "R2", "half_ready timing", half_ready, ev_p);
      if (half_ready && ev_p) chk(half_sel == evsel_p, "R2", "half_sel", half_sel, evsel_p);
      chk(restart == rs_p2, "R6", "restart timing", restart, rs_p2);
      if (restart) restarts_seen++;
      rs_p2 = rs_p1; rs_p1 = 0; ev_p = 0;
      if (!run) begin
        q_m.delete(); blk_m.delete(); wcnt = 0; playing_m = 0; hold_v = 0;
      end else begin
        if (hold_v && out_valid)
          chk({out_q, out_i} == hold_d, "R7", "stalled data stable", {out_q, out_i}, hold_d);
        hold_v = out_valid && !out_ready;
        hold_d = {out_q, out_i};
        if (out_valid && out_ready) begin
          chk(playing_m, "R4", "beat only after priming", 1, playing_m);
          if (q_m.size() == 0) chk(0, "R5", "unexpected beat", {out_q, out_i}, 0);
          else begin
            chk({out_q, out_i} == q_m[0], "R3", "pair content/order (R5)", {out_q, out_i}, q_m[0]);
            void'(q_m.pop_front());
          end
          beats++;
        end
        if (in_valid && in_ready) begin
          if ((wcnt % 2) == 0) pend_i = in_data;
          else blk_m.push_back({in_data, pend_i});
          if ((wcnt % BLK) == BLK - 1) begin
            ev_p = 1; evsel_p = ((wcnt / BLK) % 2) != 0;
            if (playing_m && ((q_m.size() + PAIRS - 1) / PAIRS) == SLOTS) begin
              rs_p1 = 1; q_m.delete(); playing_m = 0; restarts_exp++;
            end
            foreach (blk_m[k]) q_m.push_back(blk_m[k]);
            blk_m.delete();
            if (!playing_m && q_m.size() == SLOTS * PAIRS) playing_m = 1;
          end
          wcnt++;
        end
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic feed(input int n, input int gap);
    for (int k = 0; k < n; k++) begin
      in_valid = 1'b1;
      in_data  = 16'(seed * 13 + 16'h0101) ^ 16'(seed >> 3);
      seed++;
      step(1);
      in_valid = 1'b0;
      if (gap < 0) begin
        if ((k % 3) != 0) step(k % 3);
      end else if (gap > 0) step(gap);
    end
    in_valid = 1'b0;
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(2);
    // reset / stopped state
    chk(!in_ready, "R1", "in_ready low while stopped", in_ready, 0);
    chk(!out_valid && !playing, "R1", "idle after reset", {out_valid, playing}, 0);

    // steady streaming with irregular input gaps, sink always ready
    run = 1'b1; out_ready = 1'b1;
    step(1);
    feed(3 * BLK, -1);
    step(60);
    chk(!playing && !out_valid, "R4", "three blocks do not start playback", playing, 0);
    chk(beats == 0, "R5", "no beat before four blocks", beats, 0);
    feed(7 * BLK, -1);
    step(120);
    chk(playing, "R4", "playing after priming", playing, 1);
    chk(beats == 10 * PAIRS, "R5", "all pairs delivered", beats, 10 * PAIRS);
    chk(q_m.size() == 0, "R5", "model drained", q_m.size(), 0);
    chk(restarts_seen == 0, "R6", "no restart while sink keeps up", restarts_seen, 0);

    // stalled sink: fifth block collides and forces a restart
    out_ready = 1'b0;
    feed(4 * BLK, 0);
    step(40);
    chk(restarts_seen == 0, "R6", "full ring alone is no collision", restarts_seen, 0);
    feed(BLK, 1);
    step(40);
    chk(restarts_seen == 1, "R6", "collision restart", restarts_seen, 1);
    chk(!playing, "R6", "playback dropped on restart", playing, 0);
    feed(3 * BLK, 0);
    step(40);
    chk(playing && out_valid, "R4", "re-primed after restart", {playing, out_valid}, 2'b11);
    step(5);
    chk(out_valid, "R7", "valid held under stall", out_valid, 1);
    out_ready = 1'b1;
    step(120);
    chk(beats == 14 * PAIRS, "R5", "re-primed blocks delivered", beats, 14 * PAIRS);

    // stop mid-block, then restart from a clean state
    feed(BLK + 10, 0);
    step(80);
    run = 1'b0;
    step(3);
    chk(!in_ready && !playing && !out_valid, "R1", "stop halts both sides",
        {in_ready, playing, out_valid}, 0);
    run = 1'b1;
    step(1);
    feed(3 * BLK, 1);
    step(60);
    chk(!playing && !out_valid, "R4", "priming again after start", playing, 0);
    feed(BLK, 0);
    step(120);
    chk(playing, "R4", "playing after fresh priming", playing, 1);
    chk(beats == 19 * PAIRS, "R5", "all pairs after start delivered", beats, 19 * PAIRS);
    chk(q_m.size() == 0, "R5", "model empty at end", q_m.size(), 0);
    chk(restarts_seen == restarts_exp, "R6", "restart count", restarts_seen, restarts_exp);
    finish_run();
  end
endmodule